// File: doc/BRIEF.md
# SPI Master Channel

This block is one SPI master channel with a small word-addressed register port. Software sets a configuration word (clock mode, word length, clock divider, transfer direction, chip-select polarity and a forced chip-select bit), enables the channel, and moves words through a transmit register and a receive register. The channel drives SCLK, MOSI and one chip-select pin and samples MISO. A status word reports receive-ready, transmit-empty and end-of-transfer. Two level outputs mirror the transmit-empty and receive-ready flags, each gated by a configuration bit, so that an external DMA engine can pace the transfers.

Chip select is held active only while software keeps the force bit set, so several words can go out under one chip-select assertion. Besides full duplex, the channel can run transmit-only, where nothing is stored on the receive side, or receive-only. In receive-only mode one dummy write to the transmit register starts the stream, and each read of the receive register lets the next word start. An optional run-ahead mode lets one more word shift in while the previous word is still unread.

Top module: `spi_master_chan`

## Requirements
- R1: After reset, every register reads zero except the status word, which reads 3'b010 (transmit empty). The chip-select pin is inactive (high), SCLK is low and both DMA request outputs are low.
- R2: The register port is word addressed: 0 is configuration, 1 is status (bit 0 receive ready, bit 1 transmit empty, bit 2 end of transfer), 2 is control (bit 0 channel enable), 3 is the transmit register (write) and 4 is the receive register (read).
- R3: Configuration bit 1 is the idle SCLK level. Bit 0 selects the sampling edge: with bit 0 clear, MISO is sampled on the leading edge and MOSI changes on the trailing edge; with bit 0 set, the reverse. Data goes out and comes in MSB first.
- R4: Configuration bits 11:7 hold the word length minus one, for lengths of 4 to 32 bits. A field value below 3 gives 4-bit words. Received words are right-justified, with the upper bits zero.
- R5: Configuration bits 5:2 hold a divider d from 0 to 15. One SCLK period lasts 2^(d+1) clock cycles, which is the functional clock (the system clock divided by two) divided by 2^d.
- R6: Configuration bit 20 forces chip select active. The pin is low while forced when bit 6 is clear, and high while forced when bit 6 is set. A word starts shifting only while the channel is enabled and chip select is forced.
- R7: In full duplex (bits 13:12 = 00), a write to the transmit register clears transmit-empty and end-of-transfer. Transmit-empty sets again when the word moves to the shifter. At the end of the word, the received word is stored and receive-ready sets; end-of-transfer also sets if no further transmit word is pending. Reading the receive register clears receive-ready.
- R8: With bit 13 set (transmit-only), words shift as in full duplex but receive-ready never sets.
- R9: With bit 12 set (receive-only), nothing shifts after enable until the transmit register is written (dummy data). After that, a new word starts whenever receive-ready is clear, until the channel is disabled.
- R10: With bit 19 also set in receive-only mode, the next word shifts while the previous one is unread. At most one finished word waits behind the receive register, and reads return the words in arrival order.
- R11: Clearing the enable lets the word in flight finish and set receive-ready, but starts no new word. Setting the enable again discards any unread receive data.
- R12: Configuration bit 14 makes the write-request output equal transmit-empty. Bit 15 makes the read-request output equal receive-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has a side effect on the receive register) |
| reg_addr | input | 3 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_pin | output | 1 | Chip-select pin |
| dma_tx_req | output | 1 | Level request to refill the transmit register |
| dma_rx_req | output | 1 | Level request to drain the receive register |

## Verification
The embedded assertions check, on every cycle, how the flags are sequenced. A word can begin only with the channel enabled and chip select forced. Receive-ready and end-of-transfer can rise only out of a word completion. A transmit write always leaves the register full. A held run-ahead word implies receive-ready. A plain receive read drops the flag. Bit order, the four clock modes, the SCLK period, receive-only arming, run-ahead ordering and the flush on re-enable can be shown only by the bench's scenarios. A behavioural slave in the bench captures MOSI, plays words on MISO, and compares the chip-select pin against a shadow of the configuration on every clock.

// File: rtl/spi_master_chan.sv
module spi_master_chan #(
  parameter int DW  = 32,
  parameter int AW  = 3,
  parameter int HCW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          sclk,
  output logic          mosi,
  input  logic          miso,
  output logic          cs_pin,
  output logic          dma_tx_req,
  output logic          dma_rx_req
);
  localparam int LW  = $clog2(DW) + 1;
  localparam int EW  = LW + 1;
  localparam int CFW = 21;
  localparam logic [AW-1:0] A_CONF = 0, A_STAT = 1, A_CTRL = 2, A_TXD = 3, A_RXD = 4;

  logic [CFW-1:0] conf;
  logic [DW-1:0]  txbuf, rxbuf, hold, sh_tx, sh_rx;
  logic           en, tx_full, rxs, eot, hold_v, armed, busy, tog, mosi_r;
  logic [HCW-1:0] hcnt;
  logic [EW-1:0]  ecnt;

  wire       pha    = conf[0];
  wire       pol    = conf[1];
  wire [3:0] div    = conf[5:2];
  wire       cs_hi  = conf[6];
  wire [4:0] lenf   = conf[11:7];
  wire       rxonly = conf[12];
  wire       txonly = conf[13];
  wire       dmaw   = conf[14];
  wire       dmar   = conf[15];
  wire       turbo  = conf[19];
  wire       force_cs = conf[20];

  wire [LW-1:0]  wl   = (lenf < 5'd3) ? LW'(4) : LW'(lenf) + LW'(1);
  wire [HCW-1:0] hmax = (HCW'(1) << div) - HCW'(1);
  wire [DW-1:0]  tx_al = txbuf << (LW'(DW) - wl);

  wire edge_now = busy && (hcnt == hmax);
  wire lead     = ~ecnt[0];
  wire samp     = edge_now && (lead ^ pha);
  wire drv      = edge_now && !(lead ^ pha);
  wire done     = edge_now && (ecnt == {wl, 1'b0} - EW'(1));
  wire [DW-1:0] rx_next = samp ? {sh_rx[DW-2:0], miso} : sh_rx;

  wire wr_tx   = reg_wr && reg_addr == A_TXD;
  wire wr_conf = reg_wr && reg_addr == A_CONF;
  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire rd_rx   = reg_rd && reg_addr == A_RXD;
  wire en_rise = wr_ctrl && reg_wdata[0] && !en;
  wire occ_next = hold_v || (rxs && !rd_rx);

  wire start = en && force_cs && !busy && !hold_v &&
               (rxonly ? (armed && (turbo || !rxs)) : tx_full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf <= '0; txbuf <= '0; rxbuf <= '0; hold <= '0;
      sh_tx <= '0; sh_rx <= '0; hcnt <= '0; ecnt <= '0;
      en <= 1'b0; tx_full <= 1'b0; rxs <= 1'b0; eot <= 1'b0;
      hold_v <= 1'b0; armed <= 1'b0; busy <= 1'b0; tog <= 1'b0; mosi_r <= 1'b0;
    end else begin
      if (start) begin
        busy <= 1'b1; hcnt <= '0; ecnt <= '0; tog <= 1'b0;
        sh_rx <= '0; tx_full <= 1'b0;
        if (!pha) begin
          mosi_r <= tx_al[DW-1];
          sh_tx  <= tx_al << 1;
        end else begin
          sh_tx <= tx_al;
        end
      end
      if (busy) begin
        if (edge_now) begin
          hcnt <= '0; tog <= ~tog; ecnt <= ecnt + EW'(1);
        end else begin
          hcnt <= hcnt + HCW'(1);
        end
        if (drv) begin
          mosi_r <= sh_tx[DW-1];
          sh_tx  <= sh_tx << 1;
        end
        if (samp) sh_rx <= rx_next;
      end
      if (rd_rx) begin
        if (hold_v) begin
          rxbuf <= hold; hold_v <= 1'b0;
        end else begin
          rxs <= 1'b0;
        end
      end
      if (done) begin
        busy <= 1'b0;
        eot  <= !tx_full;
        if (!txonly) begin
          if (rxonly && turbo && occ_next) begin
            hold <= rx_next; hold_v <= 1'b1;
          end else begin
            rxbuf <= rx_next; rxs <= 1'b1;
          end
        end
      end
      if (wr_tx) begin
        txbuf <= reg_wdata; tx_full <= 1'b1; eot <= 1'b0;
        if (rxonly && en) armed <= 1'b1;
      end
      if (wr_conf) conf <= reg_wdata[CFW-1:0];
      if (wr_ctrl) begin
        en <= reg_wdata[0];
        if (!reg_wdata[0]) armed <= 1'b0;
        if (en_rise) begin
          rxs <= 1'b0; hold_v <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CONF:  reg_rdata = DW'(conf);
      A_STAT:  reg_rdata = DW'({eot, !tx_full, rxs});
      A_CTRL:  reg_rdata = DW'(en);
      A_RXD:   reg_rdata = rxbuf;
      default: reg_rdata = '0;
    endcase
  end

  assign sclk       = pol ^ tog;
  assign mosi       = mosi_r;
  assign cs_pin     = cs_hi ? force_cs : !force_cs;
  assign dma_tx_req = dmaw && !tx_full;
  assign dma_rx_req = dmar && rxs;

  a_r6_start_needs_force: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(en && force_cs));
  a_r7_rxs_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxs) |-> $past(done));
  a_r7_eot_from_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eot) |-> $past(done));
  a_r7_txwrite_fills: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx |=> !reg_rdata[1] || reg_addr != A_STAT || tx_full);
  a_r7_rd_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !hold_v && !done) |=> !rxs);
  a_r10_hold_implies_rxs: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v |-> rxs);
endmodule

// File: tb/spi_master_chan_tb.sv
module spi_master_chan_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        reg_wr = 0, reg_rd = 0, miso = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        sclk, mosi, cs_pin, dma_tx_req, dma_rx_req;

  spi_master_chan u_dut (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
    .reg_rdata, .sclk, .mosi, .miso, .cs_pin, .dma_tx_req, .dma_rx_req);

  int nvec = 0, nfail = 0, cyc = 0;
  logic [31:0] sh_conf = 0;
  logic [31:0] slv_q[$], cap_q[$];
  logic [31:0] cap = 0;
  int idx = 0;
  logic prev_sclk = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int wl_of(input logic [31:0] c);
    return (c[11:7] < 3) ? 4 : int'(c[11:7]) + 1;
  endfunction

  function automatic logic [31:0] msk(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
      $finish;
    end
    if (rst_n) begin
      logic expcs;
      expcs = sh_conf[6] ? sh_conf[20] : !sh_conf[20];
      chk(cs_pin === expcs, "R6 cs pin", {31'b0, cs_pin}, {31'b0, expcs});
    end
    if (rst_n && sh_conf[20]) begin
      if (sclk !== prev_sclk) begin
        bit leading;
        leading = (prev_sclk == sh_conf[1]);
        if (leading ^ sh_conf[0]) begin
          cap = (cap << 1) | {31'b0, mosi};
          idx++;
          if (idx == wl_of(sh_conf)) begin
            cap_q.push_back(cap);
            cap = 0; idx = 0;
            if (slv_q.size() > 0) void'(slv_q.pop_front());
          end
        end
      end
    end else begin
      idx = 0; cap = 0;
    end
    prev_sclk = sclk;
    miso = (slv_q.size() > 0) ? slv_q[0][wl_of(sh_conf) - 1 - idx] : 1'b0;
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    if (a == 0) sh_conf = d;
    #1 reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_stat(input logic [2:0] m, input string req);
    logic [31:0] v;
    int n = 0;
    do begin rd(1, v); n++; end while ((v[2:0] & m) != m && n < 3000);
    chk((v[2:0] & m) == m, req, v, {29'b0, m});
  endtask

  task automatic setup(input logic [31:0] c);
    wr(0, c & ~32'h0010_0000);
    slv_q.delete(); cap_q.delete();
    wr(0, c);
  endtask

  task automatic duplex(input logic [31:0] c, input logic [31:0] tx, input logic [31:0] sv, input string req);
    logic [31:0] v, m;
    m = msk(wl_of(c));
    setup(c);
    wr(2, 1);
    slv_q.push_back(sv);
    wr(3, tx);
    wait_stat(3'b101, req);
    chk(cap_q.size() == 1 && cap_q[0] == (tx & m), {req, " mosi"}, cap_q.size() ? cap_q[0] : 32'hDEAD, tx & m);
    rd(4, v);
    chk(v == (sv & m), {req, " miso"}, v, sv & m);
    rd(1, v);
    chk(v[0] == 1'b0, "R7 read clears rxs", v, 32'h6);
    chk(sclk == c[1], "R3 sclk idle level", {31'b0, sclk}, {31'b0, c[1]});
    wr(2, 0);
  endtask

  localparam logic [31:0] FRC = 32'h0010_0000;

  initial begin
    logic [31:0] v;
    int n;
    idle(3);
    rst_n = 1;
    idle(1);
    rd(1, v); chk(v == 32'h2, "R1 status reset", v, 32'h2);
    rd(0, v); chk(v == 0, "R1 conf reset", v, 0);
    rd(2, v); chk(v == 0, "R1 ctrl reset", v, 0);
    chk({cs_pin, sclk, dma_tx_req, dma_rx_req} == 4'b1000, "R1 pins", {28'b0, cs_pin, sclk, dma_tx_req, dma_rx_req}, 32'h8);

    duplex(FRC | (7 << 7),                                32'h0000_00A5, 32'h0000_003C, "R3 mode0 R4 wl8");
    duplex(FRC | (15 << 7) | 1 | (1 << 2),                32'h0000_8123, 32'h0000_F00D, "R3 mode1 wl16");
    duplex(FRC | (11 << 7) | 2,                           32'h0000_0ABC, 32'h0000_0F5A, "R3 mode2 wl12");
    duplex(FRC | (31 << 7) | 3,                           32'hDEAD_BEEF, 32'h1234_5678, "R3 mode3 R4 wl32");
    duplex(FRC | (3 << 7),                                32'hFFFF_FFF9, 32'hFFFF_FFF6, "R4 wl4");
    duplex(FRC | (1 << 7) | 1,                            32'h0000_0005, 32'h0000_000A, "R4 field below 3");
    duplex(FRC | (7 << 7) | (1 << 6),                     32'h0000_0033, 32'h0000_00CC, "R6 cs active high");

    // R5 divider d=2 -> period 8 cycles
    setup(FRC | (7 << 7) | (2 << 2));
    wr(2, 1);
    slv_q.push_back(32'h55);
    wr(3, 32'h96);
    n = 0; while (sclk !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    while (sclk !== 1'b0 && n < 400) begin @(negedge clk); n++; end
    n = 0; while (sclk !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    n = 0; while (sclk !== 1'b0 && n < 200) begin @(negedge clk); n++; end
    while (sclk !== 1'b1 && n < 400) begin @(negedge clk); n++; end
    chk(n == 8, "R5 sclk period", n, 8);
    wait_stat(3'b101, "R5 word done");
    rd(4, v); chk(v == 32'h55, "R5 data", v, 32'h55);
    wr(2, 0);

    // R6 no force: nothing starts
    setup((7 << 7));
    wr(2, 1);
    slv_q.push_back(32'h81);
    wr(3, 32'h7E);
    idle(60);
    rd(1, v); chk(v == 0, "R6 no shift without force", v, 0);
    wr(0, FRC | (7 << 7)); sh_conf = FRC | (7 << 7);
    wait_stat(3'b101, "R6 shift after force");
    rd(4, v); chk(v == 32'h81, "R6 data", v, 32'h81);
    wr(2, 0);

    // R8 transmit only, two words
    setup(FRC | (7 << 7) | (1 << 13));
    wr(2, 1);
    wr(3, 32'h11);
    wr(3, 32'h22);
    wait_stat(3'b110, "R8 tx-only done");
    rd(1, v); chk(v == 32'h6, "R8 rxs stays clear", v, 32'h6);
    chk(cap_q.size() == 2 && cap_q[0] == 32'h11 && cap_q[1] == 32'h22, "R8 both words out",
        cap_q.size(), 2);
    wr(2, 0);

    // R9 receive only
    setup(FRC | (7 << 7) | (1 << 12));
    wr(2, 1);
    slv_q.push_back(32'hA1); slv_q.push_back(32'hB2);
    idle(60);
    rd(1, v); chk(v[0] == 0 && cap_q.size() == 0, "R9 waits for dummy write", v, 32'h2);
    wr(3, 0);
    wait_stat(3'b001, "R9 first word");
    rd(4, v); chk(v == 32'hA1, "R9 word1", v, 32'hA1);
    wait_stat(3'b001, "R9 second word auto");
    wr(2, 0);
    rd(4, v); chk(v == 32'hB2, "R9 word2", v, 32'hB2);
    idle(80);
    rd(1, v); chk(v[0] == 0 && cap_q.size() == 2, "R9 stops after disable", cap_q.size(), 2);

    // R10 run-ahead receive
    setup(FRC | (7 << 7) | (1 << 12) | (1 << 19));
    wr(2, 1);
    slv_q.push_back(32'h11); slv_q.push_back(32'h22); slv_q.push_back(32'h33);
    wr(3, 0);
    idle(120);
    chk(cap_q.size() == 2, "R10 one word ahead only", cap_q.size(), 2);
    rd(4, v); chk(v == 32'h11, "R10 order first", v, 32'h11);
    rd(4, v); chk(v == 32'h22, "R10 order second", v, 32'h22);
    wr(2, 0);
    wait_stat(3'b001, "R11 in-flight completes");
    rd(4, v); chk(v == 32'h33, "R10 R11 last word", v, 32'h33);
    idle(80);
    rd(1, v); chk(v[0] == 0 && cap_q.size() == 3, "R11 no new word", cap_q.size(), 3);

    // R11 disable mid-word then re-enable flushes
    setup(FRC | (7 << 7) | (3 << 2));
    wr(2, 1);
    slv_q.push_back(32'h5A);
    wr(3, 32'hC3);
    idle(30);
    wr(2, 0);
    wait_stat(3'b001, "R11 word finishes after disable");
    chk(cap_q.size() == 1 && cap_q[0] == 32'hC3, "R11 full word out", cap_q.size(), 1);
    wr(2, 1);
    rd(1, v); chk(v[0] == 0, "R11 enable discards rx", v, 32'h6);
    rd(4, v); chk(v == 32'h5A, "R2 rx register holds last word", v, 32'h5A);
    wr(2, 0);

    // R12 DMA levels, R7 eot cleared by write
    setup(FRC | (7 << 7) | (1 << 14) | (1 << 15));
    wr(2, 1);
    idle(1);
    chk(dma_tx_req == 1 && dma_rx_req == 0, "R12 idle requests", {30'b0, dma_tx_req, dma_rx_req}, 2);
    slv_q.push_back(32'h77);
    wr(3, 32'h88);
    chk(dma_tx_req == 0, "R12 tx req drops on write", {31'b0, dma_tx_req}, 0);
    rd(1, v); chk(v[2] == 0, "R7 write clears eot", v, 0);
    wait_stat(3'b101, "R12 word done");
    chk(dma_rx_req == 1 && dma_tx_req == 1, "R12 rx req", {30'b0, dma_tx_req, dma_rx_req}, 3);
    rd(4, v);
    idle(1);
    chk(dma_rx_req == 0, "R12 rx req after read", {31'b0, dma_rx_req}, 0);
    wr(2, 0);

    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule